// File: doc/BRIEF.md
# Dual-Mode Watchdog Timer

The block is a free-running supervision counter that is clocked by its own watchdog clock and configured through a small register write port. A period-select register sets the timeout to one of eight powers of two of the watchdog clock, from 2^13 to 2^20 periods. A control register holds a start bit and a mode bit. Once the timer is started, software must write the service register before the period ends, and each write clears the counter to zero.

When the period runs out, the block raises one of two alarms, depending on the mode. In interrupt mode it sends a one-cycle non-maskable interrupt pulse, clears the counter and keeps counting, so a watchdog that is never serviced interrupts once per period. In reset mode it raises a reset request, which stays high until the dedicated watchdog reset arrives.

The start bit, the mode bit and the chosen period are sticky. Only the dedicated watchdog reset clears them. The ordinary system reset clears only the counter and the interrupt pulse.

Top module: `dmwd_top`

## Requirements
- R1: After the watchdog reset, both `nmi_o` and `rst_req_o` are 0 and the counter does not advance, so no alarm appears however long the block waits unstarted.
- R2: Writing the control register (address 1) with bit 0 = 1 starts counting. The first alarm is seen 2^(13+k) watchdog clock cycles after the clock edge that captured the start write, where k is the 3-bit period code in bits 2:0 of the period register (address 0).
- R3: In interrupt mode (control bit 1 = 0), each timeout gives an `nmi_o` pulse exactly one cycle wide. The count restarts from zero, so unserviced pulses repeat every 2^(13+k) cycles.
- R4: In reset mode (control bit 1 = 1), a timeout sets `rst_req_o`. It stays 1 through later cycles and through the system reset, and `nmi_o` never pulses.
- R5: A write to the service address (address 2, data ignored) clears the counter. The next alarm then comes 2^(13+k) cycles after the edge that captured the service write.
- R6: Writing 0 to the start bit after the timer has started has no effect, and counting continues.
- R7: Writes to the mode bit are ignored once the timer is running.
- R8: Writes to the period register are ignored once the timer is running.
- R9: Asserting `sys_rst_n_i` low clears only the counter. Start, mode and period are kept, and the next alarm comes 2^(13+k) cycles after the first edge following release, minus one.
- R10: The watchdog reset clears start, mode, period (back to code 0) and `rst_req_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Watchdog clock |
| wd_sys_rst_n_i | input | 1 | Dedicated watchdog reset, active low, clears everything |
| sys_rst_n_i | input | 1 | Ordinary system reset, active low, clears the counter and interrupt pulse only |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select: 0 period, 1 control, 2 service, 3 unused |
| wr_data_i | input | 8 | Write data |
| nmi_o | output | 1 | Non-maskable interrupt pulse |
| rst_req_o | output | 1 | Held reset request |

## Verification
The main check runs interrupt mode at the shortest period and lets three pulses go by unserviced. This separates a self-restarting counter from one that stops or drifts by a cycle. A service write, mixed with attempts to clear the start bit, flip the mode and lengthen the period, then shows which writes the running timer ignores, through the exact cycle and the kind of the next two alarms. A system reset pulse and a reset-mode run at period code 1 show which state each reset clears. A final start with no other setup shows that the watchdog reset restored period code 0 and interrupt mode.

// File: rtl/dmwd_pkg.sv
package dmwd_pkg;

  localparam int unsigned RUN_BIT  = 0;
  localparam int unsigned MODE_BIT = 1;

  typedef enum logic [1:0] {
    REG_PERIOD  = 2'd0,
    REG_CONTROL = 2'd1,
    REG_SERVICE = 2'd2,
    REG_SPARE   = 2'd3
  } reg_addr_e;

  typedef enum logic {
    MODE_NMI   = 1'b0,
    MODE_RESET = 1'b1
  } wd_mode_e;

  // Terminal count for a 2^exp period: all ones in the low exp bits.
  function automatic logic [31:0] term_value(input int unsigned exp);
    return (32'd1 << exp) - 32'd1;
  endfunction

  // Counter width that holds the longest selectable period.
  function automatic int unsigned count_width(input int unsigned min_exp,
                                              input int unsigned sel_w);
    return min_exp + (1 << sel_w) - 1;
  endfunction

endpackage

// File: rtl/dmwd_cfg_regs.sv
module dmwd_cfg_regs #(
  parameter int unsigned SEL_W  = 3,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              wd_rst_n_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              run_o,
  output logic              mode_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic              run_start_o,
  output logic              restart_o
);
  import dmwd_pkg::*;

  logic             period_wr;
  logic             control_wr;
  logic             service_wr;
  logic             run_q;
  logic             mode_q;
  logic [SEL_W-1:0] sel_q;
  logic             unused_data;

  assign period_wr  = wr_en_i && (wr_addr_i == ADDR_W'(REG_PERIOD));
  assign control_wr = wr_en_i && (wr_addr_i == ADDR_W'(REG_CONTROL));
  assign service_wr = wr_en_i && (wr_addr_i == ADDR_W'(REG_SERVICE));

  assign unused_data = ^wr_data_i[DATA_W-1:SEL_W];

  // Start event: the first write that sets the run bit.
  assign run_start_o = control_wr && wr_data_i[RUN_BIT] && !run_q;
  assign restart_o   = service_wr;

  // Period and mode may change only while stopped. Run and mode only set.
  always_ff @(posedge clk_i or negedge wd_rst_n_i) begin
    if (!wd_rst_n_i) begin
      run_q  <= 1'b0;
      mode_q <= 1'b0;
      sel_q  <= '0;
    end else begin
      if (period_wr && !run_q) begin
        sel_q <= wr_data_i[SEL_W-1:0];
      end
      if (control_wr && !run_q) begin
        mode_q <= mode_q | wr_data_i[MODE_BIT];
      end
      if (control_wr) begin
        run_q <= run_q | wr_data_i[RUN_BIT];
      end
    end
  end

  assign run_o  = run_q;
  assign mode_o = mode_q;
  assign sel_o  = sel_q;

endmodule

// File: rtl/dmwd_counter.sv
module dmwd_counter #(
  parameter int unsigned MIN_EXP = 13,
  parameter int unsigned SEL_W   = 3,
  parameter int unsigned CNT_W   = 20
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             term_hit_o
);
  localparam int unsigned NUM_SEL = 1 << SEL_W;

  logic [CNT_W-1:0] term_tbl [NUM_SEL];
  logic [CNT_W-1:0] term_sel;
  logic [CNT_W-1:0] cnt_q;

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_term
    assign term_tbl[g] = CNT_W'(dmwd_pkg::term_value(MIN_EXP + g));
  end

  assign term_sel   = term_tbl[sel_i];
  assign term_hit_o = run_i && (cnt_q == term_sel);

  // Next count: service clears, stopped holds, terminal wraps, else step.
  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] cur,
                                                  input logic run,
                                                  input logic restart,
                                                  input logic hit);
    if (restart)   return '0;
    else if (!run) return cur;
    else if (hit)  return '0;
    else           return cur + CNT_W'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= next_count(cnt_q, run_i, restart_i, term_hit_o);
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/dmwd_out_ctrl.sv
module dmwd_out_ctrl (
  input  logic clk_i,
  input  logic wd_rst_n_i,
  input  logic pulse_rst_n_i,
  input  logic timeout_i,
  input  logic mode_i,
  output logic nmi_o,
  output logic rst_req_o
);
  import dmwd_pkg::*;

  logic nmi_q;
  logic req_q;
  logic fire_nmi;
  logic fire_req;

  assign fire_nmi = timeout_i && (wd_mode_e'(mode_i) == MODE_NMI);
  assign fire_req = timeout_i && (wd_mode_e'(mode_i) == MODE_RESET);

  always_ff @(posedge clk_i or negedge pulse_rst_n_i) begin
    if (!pulse_rst_n_i) begin
      nmi_q <= 1'b0;
    end else begin
      nmi_q <= fire_nmi;
    end
  end

  always_ff @(posedge clk_i or negedge wd_rst_n_i) begin
    if (!wd_rst_n_i) begin
      req_q <= 1'b0;
    end else begin
      req_q <= req_q | fire_req;
    end
  end

  assign nmi_o     = nmi_q;
  assign rst_req_o = req_q;

endmodule

// File: rtl/dmwd_top.sv
module dmwd_top #(
  parameter int unsigned MIN_EXP = 13,
  parameter int unsigned SEL_W   = 3,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned ADDR_W  = 2
) (
  input  logic              clk_i,
  input  logic              wd_sys_rst_n_i,
  input  logic              sys_rst_n_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              nmi_o,
  output logic              rst_req_o
);
  localparam int unsigned CNT_W = dmwd_pkg::count_width(MIN_EXP, SEL_W);

  logic             run_q;
  logic             mode_q;
  logic [SEL_W-1:0] sel_q;
  logic             run_start;
  logic             restart_cmd;
  logic [CNT_W-1:0] cnt_q;
  logic             term_hit;
  logic             timeout_evt;
  logic             cnt_rst_n;

  // Counter and pulse follow either reset; config follows the watchdog reset only.
  assign cnt_rst_n = wd_sys_rst_n_i & sys_rst_n_i;

  dmwd_cfg_regs #(
    .SEL_W (SEL_W),
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) cfg_i (
    .clk_i      (clk_i),
    .wd_rst_n_i (wd_sys_rst_n_i),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .run_o      (run_q),
    .mode_o     (mode_q),
    .sel_o      (sel_q),
    .run_start_o(run_start),
    .restart_o  (restart_cmd)
  );

  dmwd_counter #(
    .MIN_EXP(MIN_EXP),
    .SEL_W  (SEL_W),
    .CNT_W  (CNT_W)
  ) cnt_i (
    .clk_i     (clk_i),
    .rst_n_i   (cnt_rst_n),
    .run_i     (run_q),
    .restart_i (restart_cmd),
    .sel_i     (sel_q),
    .cnt_o     (cnt_q),
    .term_hit_o(term_hit)
  );

  // A service write in the terminal cycle wins over the timeout.
  assign timeout_evt = term_hit && !restart_cmd;

  dmwd_out_ctrl out_i (
    .clk_i        (clk_i),
    .wd_rst_n_i   (wd_sys_rst_n_i),
    .pulse_rst_n_i(cnt_rst_n),
    .timeout_i    (timeout_evt),
    .mode_i       (mode_q),
    .nmi_o        (nmi_o),
    .rst_req_o    (rst_req_o)
  );

endmodule

// File: rtl/dmwd_checker.sv
module dmwd_checker #(
  parameter int unsigned SEL_W = 3,
  parameter int unsigned CNT_W = 20
) (
  input logic             clk_i,
  input logic             wd_rst_n,
  input logic             sys_rst_n,
  input logic             run_q,
  input logic             mode_q,
  input logic [SEL_W-1:0] sel_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             run_start,
  input logic             restart_cmd,
  input logic             timeout_evt,
  input logic             nmi_o,
  input logic             rst_req_o
);

  assert_idle_R1: assert property (@(posedge clk_i) disable iff (!wd_rst_n)
    !run_q |-> (cnt_q == '0));

  assert_start_R2: assert property (@(posedge clk_i) disable iff (!wd_rst_n || !sys_rst_n)
    run_start |=> (cnt_q == '0) && run_q);

  assert_nmi_fires_R2: assert property (@(posedge clk_i) disable iff (!wd_rst_n || !sys_rst_n)
    (timeout_evt && !mode_q) |=> nmi_o);

  assert_nmi_pulse_R3: assert property (@(posedge clk_i) disable iff (!wd_rst_n)
    nmi_o |=> !nmi_o);

  assert_req_hold_R4: assert property (@(posedge clk_i) disable iff (!wd_rst_n)
    rst_req_o |=> rst_req_o);

  assert_no_nmi_R4: assert property (@(posedge clk_i) disable iff (!wd_rst_n)
    mode_q |-> !nmi_o);

  assert_service_R5: assert property (@(posedge clk_i) disable iff (!wd_rst_n || !sys_rst_n)
    restart_cmd |=> (cnt_q == '0));

  assert_run_sticky_R6: assert property (@(posedge clk_i) disable iff (!wd_rst_n)
    run_q |=> run_q);

  assert_mode_frozen_R7: assert property (@(posedge clk_i) disable iff (!wd_rst_n)
    run_q |=> $stable(mode_q));

  assert_period_frozen_R8: assert property (@(posedge clk_i) disable iff (!wd_rst_n)
    run_q |=> $stable(sel_q));

  assert_sys_keeps_R9: assert property (@(posedge clk_i) disable iff (!wd_rst_n)
    !sys_rst_n |=> ($stable(mode_q) && $stable(sel_q)));

endmodule

bind dmwd_top dmwd_checker #(
  .SEL_W(SEL_W),
  .CNT_W(CNT_W)
) chk_i (
  .clk_i      (clk_i),
  .wd_rst_n   (wd_sys_rst_n_i),
  .sys_rst_n  (sys_rst_n_i),
  .run_q      (run_q),
  .mode_q     (mode_q),
  .sel_q      (sel_q),
  .cnt_q      (cnt_q),
  .run_start  (run_start),
  .restart_cmd(restart_cmd),
  .timeout_evt(timeout_evt),
  .nmi_o      (nmi_o),
  .rst_req_o  (rst_req_o)
);

// File: tb/dmwd_top_tb_top.sv
`timescale 1ns/1ps
module dmwd_top_tb_top;

  localparam int unsigned P0 = 8192;   // period code 0
  localparam int unsigned P1 = 16384;  // period code 1

  logic       clk = 1'b0;
  logic       wd_rst_n = 1'b0;
  logic       sys_rst_n = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       nmi;
  logic       rst_req;

  always #4 clk = ~clk;

  dmwd_top dut_i (
    .clk_i         (clk),
    .wd_sys_rst_n_i(wd_rst_n),
    .sys_rst_n_i   (sys_rst_n),
    .wr_en_i       (wr_en),
    .wr_addr_i     (wr_addr),
    .wr_data_i     (wr_data),
    .nmi_o         (nmi),
    .rst_req_o     (rst_req)
  );

  typedef struct {
    int unsigned cyc;
    bit          is_req;
    string       req;
  } exp_t;

  exp_t        exp_q[$];
  int unsigned cyc = 0;
  int          n_total = 0;
  int          n_fail = 0;
  int          n_events = 0;
  bit          done = 1'b0;
  logic        prev_req = 1'b0;
  logic        prev_nmi = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic expect_evt(input int unsigned at, input bit is_req, input string req);
    exp_t e;
    e.cyc = at; e.is_req = is_req; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic got_evt(input bit is_req);
    exp_t e;
    n_events++;
    if (exp_q.size() == 0) begin
      chk(1'b0, "R1", is_req ? "unexpected reset request at cycle" : "unexpected nmi at cycle",
          int'(cyc), -1);
    end else begin
      e = exp_q.pop_front();
      chk(e.cyc == cyc, e.req, "alarm cycle", int'(cyc), int'(e.cyc));
      chk(e.is_req == is_req, e.req, "alarm kind (1=reset request)", is_req, e.is_req);
    end
  endtask

  // Monitor: pops the expected alarms as the design raises them.
  always @(negedge clk) begin
    if (!wd_rst_n) begin
      prev_req = 1'b0;
      prev_nmi = 1'b0;
    end else begin
      if (nmi) begin
        if (prev_nmi) chk(1'b0, "R3", "nmi wider than one cycle", 2, 1);
        else got_evt(1'b0);
      end
      if (rst_req && !prev_req) got_evt(1'b1);
      prev_req = rst_req;
      prev_nmi = nmi;
    end
  end

  // Write one register; returns the count of the capturing edge.
  task automatic wr(input logic [1:0] a, input logic [7:0] d, output int unsigned edge_c);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    edge_c = cyc;
  endtask

  task automatic wait_past(input int unsigned c, input string req);
    while (cyc < c + 2) @(negedge clk);
    chk(exp_q.size() == 0, req, "expected alarms still pending", exp_q.size(), 0);
  endtask

  task automatic pulse_wd_reset();
    @(negedge clk); wd_rst_n = 1'b0;
    repeat (3) @(negedge clk);
    wd_rst_n = 1'b1;
  endtask

  initial begin
    int unsigned e;
    int unsigned k;
    int unsigned c;
    repeat (5) @(negedge clk);
    wd_rst_n = 1'b1;
    // R1: reset state and no counting while stopped
    chk(nmi == 1'b0, "R1", "nmi after reset", nmi, 0);
    chk(rst_req == 1'b0, "R1", "reset request after reset", rst_req, 0);
    repeat (P0 + 500) @(negedge clk);
    chk(n_events == 0, "R1", "alarms while stopped", n_events, 0);

    // R2, R3: interrupt mode, code 0, three unserviced periods
    wr(2'd0, 8'h00, e);
    wr(2'd1, 8'h01, e);
    expect_evt(e + P0, 1'b0, "R2");
    expect_evt(e + 2*P0, 1'b0, "R3");
    expect_evt(e + 3*P0, 1'b0, "R3");
    wait_past(e + 3*P0, "R3");

    // R6, R7, R8 ignored writes, then R5 service
    wr(2'd1, 8'h02, c);   // run=0, mode=1 attempt
    wr(2'd0, 8'h01, c);   // period code 1 attempt
    wr(2'd3, 8'hFF, c);   // spare address
    wr(2'd2, 8'h00, k);   // service
    expect_evt(k + P0, 1'b0, "R5");
    expect_evt(k + 2*P0, 1'b0, "R7_R8");
    wait_past(k + 2*P0, "R6");

    // R9: system reset keeps configuration
    @(negedge clk); sys_rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(nmi == 1'b0, "R9", "nmi held in system reset", nmi, 0);
    sys_rst_n = 1'b1;
    c = cyc;
    expect_evt(c + P0, 1'b0, "R9");
    wait_past(c + P0, "R9");

    // R10 then R4: reset mode, code 1
    pulse_wd_reset();
    chk(nmi == 1'b0, "R10", "nmi after watchdog reset", nmi, 0);
    chk(rst_req == 1'b0, "R10", "reset request after watchdog reset", rst_req, 0);
    wr(2'd0, 8'h01, e);
    wr(2'd1, 8'h03, e);
    expect_evt(e + P1, 1'b1, "R4");
    wait_past(e + P1, "R4");
    repeat (200) @(negedge clk);
    chk(rst_req == 1'b1, "R4", "reset request held", rst_req, 1);
    @(negedge clk); sys_rst_n = 1'b0;
    repeat (2) @(negedge clk);
    sys_rst_n = 1'b1;
    @(negedge clk);
    chk(rst_req == 1'b1, "R4", "reset request through system reset", rst_req, 1);

    // R10: watchdog reset clears request, mode and period
    pulse_wd_reset();
    chk(rst_req == 1'b0, "R10", "reset request cleared", rst_req, 0);
    wr(2'd1, 8'h01, e);
    expect_evt(e + P0, 1'b0, "R10");
    wait_past(e + P0, "R10");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_total++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

endmodule